// File: doc/BRIEF.md
# Gated Sticky Interrupt Status Register

This block collects hardware event inputs into a status word of sticky bits and raises one interrupt line while any bit is set. Each instance is built for one detection mode. High-level mode sets a bit while its input is 1. Rise mode sets a bit on a 0-to-1 change. Fall mode sets a bit on a 1-to-0 change. Any-edge mode sets a bit on either change. Once a bit is set, it stays set until software clears it by writing a 1 to that bit position.

The status word has a low group, bits LO_W-1:0, and a high group of HI_W bits above it. With the defaults the low group is bits 7:0 and the high group is bit 8. Each group has its own hardware write-enable qualifier. An event can set bits in a group only while that group's qualifier is active. A parameter chooses whether the qualifier is active high or active low. An event that arrives while the qualifier is inactive is dropped. It is not held back and applied later. Software reads the whole word on a plain read port with no wait states and clears bits through a one-cycle write strobe.

Top module: `irq_sticky_status`

## Requirements
- R1: Synchronous reset clears every status bit, the stored previous-input copies and the interrupt output.
- R2: A set bit holds its value after its input returns to the idle level, and only a software clear or a reset removes it.
- R3: In high-level mode (MODE = DET_LEVEL), a bit is set in any cycle where its input is 1 and its group qualifier is active.
- R4: In rise mode (MODE = DET_RISE), a bit is set only on a 0-to-1 change of its input. An input that stays high does not set the bit again after software clears it.
- R5: In fall mode (MODE = DET_FALL), a bit is set only on a 1-to-0 change of its input. Rising or holding high sets nothing.
- R6: In any-edge mode (MODE = DET_ANY), a rise sets the bit. After software clears it, the next fall sets it again.
- R7: A software write (sw_wr = 1) clears each bit whose sw_wdata bit is 1. A 0 in sw_wdata leaves that bit unchanged. Writing 0x1FF clears the whole default 9-bit word.
- R8: An event seen while the qualifier is inactive leaves the status unchanged. The event is not captured later when the qualifier turns active. Edge detection compares each input with a copy taken on the previous cycle, and that copy updates every cycle whatever the qualifier is.
- R9: With WE_ACTIVE_LOW = 0, an enable input of 1 is the active level. With WE_ACTIVE_LOW = 1, an enable input of 0 is the active level.
- R10: en_lo gates only bits LO_W-1:0 and en_hi gates only the HI_W bits above them.
- R11: irq is 1 exactly when at least one status bit is set. It drops in the same cycle that the last set bit is cleared.
- R12: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_lo | input | LO_W | Event inputs for the low group |
| evt_hi | input | HI_W | Event inputs for the high group |
| en_lo | input | 1 | Hardware write-enable qualifier for the low group; active level set by WE_ACTIVE_LOW |
| en_hi | input | 1 | Hardware write-enable qualifier for the high group; active level set by WE_ACTIVE_LOW |
| sw_wr | input | 1 | Software write strobe; one cycle per write |
| sw_wdata | input | LO_W+HI_W | Write-one-to-clear mask; 1 clears the bit at that position |
| sw_rdata | output | LO_W+HI_W | Current status word; the high group occupies the top HI_W bits |
| irq | output | 1 | OR of all status bits |

## Verification
The bench runs four instances side by side, one for each detection mode, and drives them from the same event inputs. A held-high input tells level mode apart from rise mode, because only level mode keeps setting the bit after a clear. A falling input tells fall mode and any-edge mode apart from rise mode. Events are applied with the qualifier inactive and the qualifier is then switched on with the input unchanged. This shows that the event was dropped and not deferred. It also shows that the active-low instance reacts to the opposite enable level. Other patterns enable one group at a time, clear part of the word, and apply a set and a clear to the same bit in the same cycle. These show that the groups are independent, that clears act only on the masked bits, and that the set takes priority.

// File: rtl/irq_sticky_pkg.sv
package irq_sticky_pkg;

  // How an event input is turned into a set request.
  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_ANY   = 2'd3
  } det_mode_e;

endpackage

// File: rtl/irq_evt_detect.sv
module irq_evt_detect
  import irq_sticky_pkg::*;
#(
  parameter int        W    = 8,
  parameter det_mode_e MODE = DET_ANY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] hit_o
);

  // Previous-cycle copy; it updates on every cycle, whatever the qualifier is.
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= evt_i;
  end

  generate
    if (MODE == DET_LEVEL) begin : g_level
      assign hit_o = evt_i;
    end else if (MODE == DET_RISE) begin : g_rise
      assign hit_o = evt_i & ~prev_q;
    end else if (MODE == DET_FALL) begin : g_fall
      assign hit_o = ~evt_i & prev_q;
    end else begin : g_any
      assign hit_o = evt_i ^ prev_q;
    end
  endgenerate

endmodule

// File: rtl/irq_we_qual.sv
module irq_we_qual #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic en_i,
  output logic ok_o
);

  generate
    if (ACTIVE_LOW) begin : g_low
      assign ok_o = ~en_i;
    end else begin : g_high
      assign ok_o = en_i;
    end
  endgenerate

endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
        if (rst)           q <= 1'b0;
        else if (set_i[b]) q <= 1'b1;  // a hardware set beats a clear
        else if (clr_i[b]) q <= 1'b0;
      end
      assign q_o[b] = q;
    end
  endgenerate

endmodule

// File: rtl/irq_sticky_status.sv
module irq_sticky_status
  import irq_sticky_pkg::*;
#(
  parameter int        LO_W          = 8,
  parameter int        HI_W          = 1,
  parameter det_mode_e MODE          = DET_ANY,
  parameter bit        WE_ACTIVE_LOW = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LO_W-1:0]      evt_lo,
  input  logic [HI_W-1:0]      evt_hi,
  input  logic                 en_lo,
  input  logic                 en_hi,
  input  logic                 sw_wr,
  input  logic [LO_W+HI_W-1:0] sw_wdata,
  output logic [LO_W+HI_W-1:0] sw_rdata,
  output logic                 irq
);

  localparam int TOT_W = LO_W + HI_W;

  logic [LO_W-1:0]  hit_lo, set_lo, st_lo;
  logic [HI_W-1:0]  hit_hi, set_hi, st_hi;
  logic             ok_lo, ok_hi;
  logic [TOT_W-1:0] clr_mask;

  assign clr_mask = sw_wr ? sw_wdata : '0;

  // Low group
  irq_evt_detect #(.W(LO_W), .MODE(MODE)) u_det_lo (
    .clk(clk), .rst(rst), .evt_i(evt_lo), .hit_o(hit_lo)
  );
  irq_we_qual #(.ACTIVE_LOW(WE_ACTIVE_LOW)) u_qual_lo (
    .en_i(en_lo), .ok_o(ok_lo)
  );
  assign set_lo = ok_lo ? hit_lo : '0;
  irq_sticky_bank #(.W(LO_W)) u_bank_lo (
    .clk(clk), .rst(rst), .set_i(set_lo),
    .clr_i(clr_mask[LO_W-1:0]), .q_o(st_lo)
  );

  // High group
  irq_evt_detect #(.W(HI_W), .MODE(MODE)) u_det_hi (
    .clk(clk), .rst(rst), .evt_i(evt_hi), .hit_o(hit_hi)
  );
  irq_we_qual #(.ACTIVE_LOW(WE_ACTIVE_LOW)) u_qual_hi (
    .en_i(en_hi), .ok_o(ok_hi)
  );
  assign set_hi = ok_hi ? hit_hi : '0;
  irq_sticky_bank #(.W(HI_W)) u_bank_hi (
    .clk(clk), .rst(rst), .set_i(set_hi),
    .clr_i(clr_mask[TOT_W-1:LO_W]), .q_o(st_hi)
  );

  assign sw_rdata = {st_hi, st_lo};
  assign irq      = |sw_rdata;

endmodule

// File: rtl/irq_sticky_status_chk.sv
module irq_sticky_status_chk #(
  parameter int LO_W          = 8,
  parameter int HI_W          = 1,
  parameter bit WE_ACTIVE_LOW = 1'b0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en_lo,
  input logic                 en_hi,
  input logic                 sw_wr,
  input logic [LO_W+HI_W-1:0] sw_wdata,
  input logic [LO_W+HI_W-1:0] sw_rdata
);

  localparam int TOT_W = LO_W + HI_W;

  logic act_lo, act_hi;
  assign act_lo = WE_ACTIVE_LOW ? !en_lo : en_lo;
  assign act_hi = WE_ACTIVE_LOW ? !en_hi : en_hi;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sw_rdata == '0)); // R1

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sw_wr |=> (($past(sw_rdata) & ~sw_rdata) == '0)); // R2

  AST_W1C_GATED: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && !act_lo && !act_hi) |=> ((sw_rdata & $past(sw_wdata)) == '0)); // R7

  AST_LO_NO_SET_GATED: assert property (@(posedge clk) disable iff (rst)
    !act_lo |=> ((sw_rdata[LO_W-1:0] & ~$past(sw_rdata[LO_W-1:0])) == '0)); // R8

  AST_HI_NO_SET_GATED: assert property (@(posedge clk) disable iff (rst)
    !act_hi |=> ((sw_rdata[TOT_W-1:LO_W] & ~$past(sw_rdata[TOT_W-1:LO_W])) == '0)); // R10

endmodule

bind irq_sticky_status irq_sticky_status_chk #(
  .LO_W(LO_W), .HI_W(HI_W), .WE_ACTIVE_LOW(WE_ACTIVE_LOW)
) u_chk (
  .clk(clk), .rst(rst), .en_lo(en_lo), .en_hi(en_hi),
  .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
);

// File: tb/test_irq_sticky_status.sv
`timescale 1ns/1ps
module test_irq_sticky_status;
  import irq_sticky_pkg::*;

  // Instance roles: 0 = any-edge, 1 = high-level with active-low enable,
  // 2 = rise, 3 = fall. Instances 0, 2 and 3 use active-high enables.
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt_lo = '0;
  logic [0:0] evt_hi = '0;
  logic       qa_lo = 1'b0, qa_hi = 1'b0;  // logical "qualifier active"
  logic       sw_wr = 1'b0;
  logic [8:0] sw_wdata = '0;
  logic [8:0] rd [4];
  logic       irq_v [4];
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_sticky_status #(.MODE(DET_ANY), .WE_ACTIVE_LOW(1'b0)) i_irq_sticky_status (
    .clk(clk), .rst(rst), .evt_lo(evt_lo), .evt_hi(evt_hi), .en_lo(qa_lo), .en_hi(qa_hi),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(rd[0]), .irq(irq_v[0]));
  irq_sticky_status #(.MODE(DET_LEVEL), .WE_ACTIVE_LOW(1'b1)) i_irq_sticky_status_lvl (
    .clk(clk), .rst(rst), .evt_lo(evt_lo), .evt_hi(evt_hi), .en_lo(~qa_lo), .en_hi(~qa_hi),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(rd[1]), .irq(irq_v[1]));
  irq_sticky_status #(.MODE(DET_RISE), .WE_ACTIVE_LOW(1'b0)) i_irq_sticky_status_rise (
    .clk(clk), .rst(rst), .evt_lo(evt_lo), .evt_hi(evt_hi), .en_lo(qa_lo), .en_hi(qa_hi),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(rd[2]), .irq(irq_v[2]));
  irq_sticky_status #(.MODE(DET_FALL), .WE_ACTIVE_LOW(1'b0)) i_irq_sticky_status_fall (
    .clk(clk), .rst(rst), .evt_lo(evt_lo), .evt_hi(evt_hi), .en_lo(qa_lo), .en_hi(qa_hi),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(rd[3]), .irq(irq_v[3]));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%03h expected=0x%03h", req, act, exp);
    end
  endtask

  // One rising edge passes; returns at the following falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sw_clear(input logic [8:0] mask);
    sw_wr = 1'b1; sw_wdata = mask;
    step();
    sw_wr = 1'b0; sw_wdata = '0;
  endtask

  task automatic cleanup();
    qa_lo = 1'b0; qa_hi = 1'b0; evt_lo = '0; evt_hi = '0;
    step();
    sw_clear(9'h1FF);
    step();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      chk("R1 status after reset", rd[i], 9'h000);
      chk("R1 irq after reset", {8'h0, irq_v[i]}, 9'h000);
    end
  endtask

  task automatic t_level();
    qa_lo = 1'b0; evt_lo = 8'h0F;          // raw enable of active-low instance = 1
    step();
    chk("R9 active-low enable at 1 blocks", rd[1], 9'h000);
    qa_lo = 1'b1;                           // raw enable = 0 -> active
    step();
    chk("R3 level sets while high", rd[1], 9'h00F);
    chk("R9 active-low enable at 0 allows", rd[1], 9'h00F);
    evt_lo = 8'h00;
    step();
    chk("R2 level bits stay set", rd[1], 9'h00F);
    chk("R11 irq with bits set", {8'h0, irq_v[1]}, 9'h001);
    cleanup();
  endtask

  task automatic t_rise();
    qa_hi = 1'b1; evt_hi = 1'b1;
    step();
    chk("R4 rise sets bit 8", rd[2], 9'h100);
    sw_clear(9'h100);                       // input still held high
    chk("R4 held high does not re-set", rd[2], 9'h000);
    cleanup();
  endtask

  task automatic t_fall();
    qa_lo = 1'b1; evt_lo = 8'h81;
    step();
    chk("R5 rise ignored in fall mode", rd[3], 9'h000);
    evt_lo = 8'h00;
    step();
    chk("R5 fall sets bits", rd[3], 9'h081);
    cleanup();
  endtask

  task automatic t_both();
    qa_hi = 1'b1; evt_hi = 1'b1;
    step();
    chk("R6 rise sets in any-edge", rd[0], 9'h100);
    chk("R11 irq high", {8'h0, irq_v[0]}, 9'h001);
    sw_clear(9'h100);
    chk("R7 cleared by write one", rd[0], 9'h000);
    chk("R11 irq drops after clear", {8'h0, irq_v[0]}, 9'h000);
    evt_hi = 1'b0;
    step();
    chk("R6 following fall sets again", rd[0], 9'h100);
    cleanup();
  endtask

  task automatic t_w1c();
    qa_lo = 1'b1; qa_hi = 1'b1; evt_lo = 8'hFF; evt_hi = 1'b1;
    step();
    chk("R4 all bits rise", rd[2], 9'h1FF);
    qa_lo = 1'b0; qa_hi = 1'b0; evt_lo = 8'h00; evt_hi = 1'b0;
    step();
    chk("R2 any-edge word held", rd[0], 9'h1FF);
    sw_clear(9'h0F0);
    chk("R7 partial clear", rd[0], 9'h10F);
    sw_clear(9'h000);
    chk("R7 zeros leave bits", rd[0], 9'h10F);
    sw_clear(9'h1FF);
    chk("R7 0x1FF clears all", rd[0], 9'h000);
    chk("R11 irq low when empty", {8'h0, irq_v[0]}, 9'h000);
    cleanup();
  endtask

  task automatic t_gate();
    qa_lo = 1'b0; evt_lo = 8'h0F;
    step();
    chk("R8 gated rise dropped (any)", rd[0], 9'h000);
    chk("R8 gated rise dropped (rise)", rd[2], 9'h000);
    qa_lo = 1'b1;                           // input held, qualifier now on
    step();
    chk("R8 rise not captured later", rd[2], 9'h000);
    chk("R8 any-edge not captured later", rd[0], 9'h000);
    cleanup();
    qa_lo = 1'b0; evt_lo = 8'h01;
    step();
    evt_lo = 8'h00;
    step();
    qa_lo = 1'b1;
    step();
    chk("R8 gated level pulse dropped", rd[1], 9'h000);
    cleanup();
  endtask

  task automatic t_group();
    qa_lo = 1'b1; qa_hi = 1'b0; evt_lo = 8'h03; evt_hi = 1'b1;
    step();
    chk("R10 only low group sets", rd[2], 9'h003);
    qa_lo = 1'b0; qa_hi = 1'b1; evt_lo = 8'h00; evt_hi = 1'b0;
    step();
    evt_lo = 8'h0C; evt_hi = 1'b1;
    step();
    chk("R10 only high group sets", rd[2], 9'h103);
    cleanup();
  endtask

  task automatic t_setwins();
    qa_hi = 1'b1; evt_hi = 1'b1;
    sw_wr = 1'b1; sw_wdata = 9'h100;
    step();
    sw_wr = 1'b0; sw_wdata = '0;
    chk("R12 set beats clear", rd[2], 9'h100);
    cleanup();
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_w1c();
    t_gate();
    t_group();
    t_setwins();
    summary();
    $finish;
  end

endmodule